// File: doc/BRIEF.md
# Prefix-OR Leading Zero Counter

This block counts how many zero bits sit above the most significant set bit of an N-bit operand. It also reports whether any bit is set at all. It is meant for the normalization step of a floating-point datapath. The count drives the left shift of the mantissa and the exponent correction, both of which sit outside this block.

Inside, the operand is first turned into a monotonic prefix-OR string. Bit i of that string is set when any operand bit at position i or above is set. The count is then formed in two independent ways:

- **Encoder path.** A one-hot leading-digit word is marked from the prefix string, and a weighted encoder turns it into a binary count.
- **Reduced path.** Each count bit is taken straight from adjacent-base pairs of the prefix string.

Both counts leave the block, together with a flag that is raised if they ever disagree. A parameter selects either purely combinational outputs or outputs held in a register stage. The register stage adds one cycle of latency and clears to zero in reset.

Top module: `prefix_lzc`

## Requirements
- R1: For a nonzero operand, `lz_count` (reduced path) equals N-1-p, where p is the index of the highest set bit. Bit N-1 is the most significant, so bit N-1 alone gives 0 and bit 0 alone gives N-1.
- R2: For every operand, `lz_count_enc` (one-hot plus encoder path) carries the same value as R1 requires of `lz_count`.
- R3: For an all-zero operand, both counts are 0 and `nonzero` is 0.
- R4: `nonzero` is 1 exactly when at least one operand bit is 1.
- R5: `path_mismatch` is 0 for every operand.
- R6: With `REG_OUT`=1 (the default), each output reflects the operand present at the previous rising edge of `clk`. Before that edge, the outputs keep their old values. While `rst_n` is low, all outputs are 0.
- R7: Bits below the highest set bit have no effect on either count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| operand | input | N | Value to be counted, bit N-1 most significant |
| lz_count | output | log2(N) | Leading zero count from the reduced prefix relations |
| lz_count_enc | output | log2(N) | Leading zero count from the one-hot encoder path |
| nonzero | output | 1 | High when any operand bit is set |
| path_mismatch | output | 1 | High when the two counts differ |

## Verification
The zero-operand forcing and the cross-check of the two count paths act in the same cycle whenever the operand is all zero. In that case the encoder sees an empty one-hot word, while the reduced path relies on the lowest prefix bit to gate its terms. The bench places all-zero operands directly between single-one and dense random operands. It then requires both counts to be 0, `nonzero` to be low, and `path_mismatch` to stay low. The checker confirms the same agreement on every clocked cycle.

// File: rtl/lzc_pkg.sv
`timescale 1ns/1ps
package lzc_pkg;

  // bit k of the zero run that a leading digit at position i stands for
  function automatic bit enc_sel(int n, int i, int k);
    int run;
    run = n - 1 - i;
    return ((run >> k) & 1) == 1;
  endfunction

  // base index of the upper half of group g for count bit k
  function automatic int red_hi(int k, int g);
    return g * (2 << k) + (1 << k);
  endfunction

  // base index of the lower half of group g for count bit k
  function automatic int red_lo(int k, int g);
    return g * (2 << k);
  endfunction

endpackage

// File: rtl/lzc_prefix_or.sv
`timescale 1ns/1ps
module lzc_prefix_or #(
  parameter int N = 16
) (
  input  logic [N-1:0] a_in,
  output logic [N-1:0] s_str
);
  assign s_str[N-1] = a_in[N-1];
  for (genvar i = N - 2; i >= 0; i--) begin : g_chain
    assign s_str[i] = s_str[i+1] | a_in[i];
  end
endmodule

// File: rtl/lzc_lead_onehot.sv
`timescale 1ns/1ps
module lzc_lead_onehot #(
  parameter int N = 16
) (
  input  logic [N-1:0] a_in,
  input  logic [N-1:0] s_str,
  output logic [N-1:0] lead
);
  assign lead[N-1] = s_str[N-1];
  for (genvar i = 0; i < N - 1; i++) begin : g_mark
    assign lead[i] = ~s_str[i+1] & a_in[i];
  end
endmodule

// File: rtl/lzc_onehot_enc.sv
`timescale 1ns/1ps
module lzc_onehot_enc #(
  parameter  int N  = 16,
  localparam int ZW = $clog2(N)
) (
  input  logic [N-1:0]  lead,
  output logic [ZW-1:0] cnt
);
  for (genvar k = 0; k < ZW; k++) begin : g_bit
    logic [N-1:0] sel;
    for (genvar i = 0; i < N; i++) begin : g_pos
      if (lzc_pkg::enc_sel(N, i, k)) begin : g_on
        assign sel[i] = lead[i];
      end else begin : g_off
        assign sel[i] = 1'b0;
      end
    end
    assign cnt[k] = |sel;
  end
endmodule

// File: rtl/lzc_reduced.sv
`timescale 1ns/1ps
module lzc_reduced #(
  parameter  int N  = 16,
  localparam int ZW = $clog2(N)
) (
  input  logic [N-1:0]  s_str,
  output logic [ZW-1:0] cnt
);
  for (genvar k = 0; k < ZW; k++) begin : g_bit
    localparam int GROUPS = N >> (k + 1);
    logic [GROUPS-1:0] pair_hit;
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      assign pair_hit[g] = ~s_str[lzc_pkg::red_hi(k, g)] & s_str[lzc_pkg::red_lo(k, g)];
    end
    assign cnt[k] = |pair_hit;
  end
endmodule

// File: rtl/prefix_lzc.sv
`timescale 1ns/1ps
module prefix_lzc #(
  parameter  int N       = 16,
  parameter  bit REG_OUT = 1'b1,
  localparam int ZW      = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  operand,
  output logic [ZW-1:0] lz_count,
  output logic [ZW-1:0] lz_count_enc,
  output logic          nonzero,
  output logic          path_mismatch
);
  logic [N-1:0]  s_string;
  logic [N-1:0]  l_word;
  logic [ZW-1:0] cnt_red;
  logic [ZW-1:0] cnt_enc;
  logic          any_c;
  logic          diff_c;

  lzc_prefix_or #(.N(N)) u_prefix (
    .a_in  (operand),
    .s_str (s_string)
  );

  lzc_lead_onehot #(.N(N)) u_lead (
    .a_in  (operand),
    .s_str (s_string),
    .lead  (l_word)
  );

  lzc_onehot_enc #(.N(N)) u_enc (
    .lead (l_word),
    .cnt  (cnt_enc)
  );

  lzc_reduced #(.N(N)) u_red (
    .s_str (s_string),
    .cnt   (cnt_red)
  );

  assign any_c  = s_string[0];
  assign diff_c = (cnt_red != cnt_enc);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lz_count      <= '0;
        lz_count_enc  <= '0;
        nonzero       <= 1'b0;
        path_mismatch <= 1'b0;
      end else begin
        lz_count      <= cnt_red;
        lz_count_enc  <= cnt_enc;
        nonzero       <= any_c;
        path_mismatch <= diff_c;
      end
    end
  end else begin : g_comb
    assign lz_count      = cnt_red;
    assign lz_count_enc  = cnt_enc;
    assign nonzero       = any_c;
    assign path_mismatch = diff_c;
  end
endmodule

// File: rtl/lzc_checker.sv
`timescale 1ns/1ps
module lzc_checker #(
  parameter  int N       = 16,
  parameter  bit REG_OUT = 1'b1,
  localparam int ZW      = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  operand,
  input logic [ZW-1:0] lz_count,
  input logic [ZW-1:0] lz_count_enc,
  input logic          nonzero,
  input logic          path_mismatch,
  input logic [N-1:0]  s_string,
  input logic [N-1:0]  l_word
);
  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  // R5
  no_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !path_mismatch);

  // R2
  paths_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lz_count == lz_count_enc);

  // R3
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nonzero |-> (lz_count == '0 && lz_count_enc == '0));

  // R1
  prefix_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((s_string >> 1) & ~s_string) == '0);

  // R1
  lead_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(l_word) && ((l_word != '0) == (operand != '0)));

  if (REG_OUT) begin : g_lat
    // R6
    flag_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      primed |=> nonzero == $past(operand != '0));
  end
endmodule

bind prefix_lzc lzc_checker #(.N(N), .REG_OUT(REG_OUT)) u_lzc_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .operand       (operand),
  .lz_count      (lz_count),
  .lz_count_enc  (lz_count_enc),
  .nonzero       (nonzero),
  .path_mismatch (path_mismatch),
  .s_string      (s_string),
  .l_word        (l_word)
);

// File: tb/test_prefix_lzc.sv
`timescale 1ns/1ps
module test_prefix_lzc;
  localparam int N  = 16;
  localparam int ZW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  operand = '0;
  logic [ZW-1:0] lz_count;
  logic [ZW-1:0] lz_count_enc;
  logic          nonzero;
  logic          path_mismatch;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  prefix_lzc #(.N(N), .REG_OUT(1'b1)) i_prefix_lzc (
    .clk           (clk),
    .rst_n         (rst_n),
    .operand       (operand),
    .lz_count      (lz_count),
    .lz_count_enc  (lz_count_enc),
    .nonzero       (nonzero),
    .path_mismatch (path_mismatch)
  );

  function automatic int ref_lz(logic [N-1:0] v);
    int run = 0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) return run;
      run++;
    end
    return 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic [N-1:0] last_v = '0;

  // caller is at a falling edge; one cycle per operand
  task automatic apply(logic [N-1:0] v, string tag);
    operand = v;
    #1;
    chk("R6 hold", int'(lz_count), ref_lz(last_v));
    @(negedge clk);
    chk({"R1 ", tag}, int'(lz_count), ref_lz(v));
    chk({"R2 ", tag}, int'(lz_count_enc), ref_lz(v));
    chk({"R4 ", tag}, int'(nonzero), int'(v != '0));
    chk({"R5 ", tag}, int'(path_mismatch), 0);
    if (v == '0) begin
      chk("R3 count", int'(lz_count), 0);
      chk("R3 flag", int'(nonzero), 0);
    end
    last_v = v;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R6 watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    logic [N-1:0] lower;
    int p;
    void'($urandom(32'd20240611));
    operand = '1;
    repeat (3) @(negedge clk);
    chk("R6 reset count", int'(lz_count), 0);
    chk("R6 reset enc", int'(lz_count_enc), 0);
    chk("R6 reset flag", int'(nonzero), 0);
    chk("R6 reset mismatch", int'(path_mismatch), 0);
    operand = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    apply('0, "zero");
    apply('1, "all ones");
    apply(16'h2001, "0x2001");
    chk("R1 0x2001 is 2", int'(lz_count), 2);
    apply(16'h001A, "0x001A");
    apply('0, "zero after dense");
    for (int i = 0; i < N; i++) begin
      apply(N'(1) << i, "single one");
      apply('0, "zero between singles");
    end
    // R7: lower bits below the leading digit have no effect
    for (int t = 0; t < 200; t++) begin
      p = $urandom_range(0, N - 1);
      lower = N'($urandom()) & ((N'(1) << p) - N'(1));
      v = (N'(1) << p) | lower;
      apply(v, "R7 lower bits");
      chk("R7 count", int'(lz_count), N - 1 - p);
    end
    for (int t = 0; t < 3000; t++) begin
      v = N'($urandom());
      case ($urandom_range(0, 3))
        0: v = v >> $urandom_range(0, N - 1);
        1: v = v & N'($urandom()) & N'($urandom());
        2: v = '0;
        default: ;
      endcase
      apply(v, "random");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule